// File: doc/BRIEF.md
# Byte-Split Processor Register File

This block holds the programmer-visible state of a 16-bit processor: four general registers (accumulator, count, data, base), four pointer and index registers, four segment registers, the instruction pointer and the flags word. Each general register can be reached as a whole word or as either of its two bytes. Two read ports return data in the same cycle. A write through the single general write port takes effect at the next rising clock edge.

Beside the general port, three side ports serve operations that name their registers implicitly. A loop port decrements the count register and reports whether the loop branch is taken. A wide-result port writes the data:accumulator pair in one cycle. An instruction-pointer port loads a new target or advances the pointer by a step. The block also presents the physical fetch address, which is the code segment shifted left by four plus the instruction pointer.

Top module: `cpu_regbank`

## Requirements
- R1: After reset every register reads 0 except the code segment, which reads 0xFFFF, so fetch_addr is 0xFFFF0.
- R2: In word mode (byte bit 0) the 4-bit select picks 0 AX, 1 CX, 2 DX, 3 BX, 4 SP, 5 BP, 6 SI, 7 DI, 8 ES, 9 CS, 10 SS, 11 DS, 12 IP, 13 FLAGS. Selects 14 and 15 read 0 and ignore writes. Reads are combinational and a write is visible after the next rising edge.
- R3: In byte mode (byte bit 1) with select bit 3 clear, select bits 1:0 pick AX, CX, DX, BX in that order and select bit 2 picks the high byte. A byte read returns the byte zero-extended. A byte write stores wr_data[7:0] and leaves the other byte of that register unchanged.
- R4: In byte mode with select bit 3 set, a read returns 0 and a write changes no register.
- R5: loop_dec decrements CX by one at the next edge, and 0 wraps to 0xFFFF. In the same cycle loop_taken is 1 exactly when the decremented value is nonzero.
- R6: wide_we writes wide_lo into AX and wide_hi into DX at the next edge.
- R7: ip_load sets IP to ip_target. Otherwise ip_inc adds ip_step to IP. ip_load wins when both are asserted.
- R8: When a side port and the general write port target the same register in one cycle, the side port's value is stored.
- R9: fetch_addr equals CS times 16 plus IP, modulo 2^20.
- R10: The two read ports select independently and can read different registers, or different widths, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_sel | input | 4 | Read port A register select |
| rd_a_byte | input | 1 | Read port A byte mode |
| rd_a_data | output | 16 | Read port A data |
| rd_b_sel | input | 4 | Read port B register select |
| rd_b_byte | input | 1 | Read port B byte mode |
| rd_b_data | output | 16 | Read port B data |
| wr_en | input | 1 | General write enable |
| wr_sel | input | 4 | General write register select |
| wr_byte | input | 1 | General write byte mode |
| wr_data | input | 16 | General write data (low byte used in byte mode) |
| loop_dec | input | 1 | Decrement the count register |
| loop_taken | output | 1 | Count stays nonzero after this decrement |
| wide_we | input | 1 | Write the DX:AX pair |
| wide_hi | input | 16 | Upper half of the wide result, to DX |
| wide_lo | input | 16 | Lower half of the wide result, to AX |
| ip_load | input | 1 | Load the instruction pointer |
| ip_target | input | 16 | New instruction pointer value |
| ip_inc | input | 1 | Advance the instruction pointer |
| ip_step | input | 16 | Amount to advance by |
| fetch_addr | output | 20 | Segment-shifted fetch address |

## Verification
The bench builds the block with its default parameters: a 16-bit word, a segment shift of four and a 20-bit fetch address. These defaults allow the bench to drive the count register to 0 and 1 and check the wrap to 0xFFFF. They also allow a fetch-address sum that carries past bit 19, and a byte write to each half of a register whose other half holds a known, distinct value. The same defaults cover every same-cycle conflict between a side port and the general write port.

// File: rtl/cpu_regbank.sv
`timescale 1ns/1ps
module cpu_regbank #(
  parameter int W         = 16,
  parameter int SEG_SHIFT = 4,
  parameter int ADDR_W    = W + SEG_SHIFT,
  parameter logic [W-1:0] CS_RST = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        rd_a_sel,
  input  logic              rd_a_byte,
  output logic [W-1:0]      rd_a_data,
  input  logic [3:0]        rd_b_sel,
  input  logic              rd_b_byte,
  output logic [W-1:0]      rd_b_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_sel,
  input  logic              wr_byte,
  input  logic [W-1:0]      wr_data,
  input  logic              loop_dec,
  output logic              loop_taken,
  input  logic              wide_we,
  input  logic [W-1:0]      wide_hi,
  input  logic [W-1:0]      wide_lo,
  input  logic              ip_load,
  input  logic [W-1:0]      ip_target,
  input  logic              ip_inc,
  input  logic [W-1:0]      ip_step,
  output logic [ADDR_W-1:0] fetch_addr
);
  localparam int HB = W / 2;
  localparam logic [3:0] I_AX = 4'd0, I_CX = 4'd1, I_DX = 4'd2;
  localparam logic [3:0] I_CS = 4'd9, I_IP = 4'd12, I_LAST = 4'd13;

  logic [W-1:0] regs [16];
  logic [W-1:0] nxt  [16];

  function automatic logic [W-1:0] rd_mux(input logic [3:0] s, input logic b);
    logic [W-1:0] g;
    g = regs[{2'b00, s[1:0]}];
    if (!b)        return regs[s];
    else if (s[3]) return '0;
    else if (s[2]) return {{(W-HB){1'b0}}, g[W-1:HB]};
    else           return {{(W-HB){1'b0}}, g[HB-1:0]};
  endfunction

  assign rd_a_data  = rd_mux(rd_a_sel, rd_a_byte);
  assign rd_b_data  = rd_mux(rd_b_sel, rd_b_byte);
  assign loop_taken = loop_dec & (regs[I_CX] != W'(1));
  assign fetch_addr = ADDR_W'({regs[I_CS], {SEG_SHIFT{1'b0}}}) + ADDR_W'(regs[I_IP]);

  // general port first, side ports afterwards so they override (R8)
  always_comb begin
    nxt = regs;
    if (wr_en) begin
      if (!wr_byte) begin
        if (wr_sel <= I_LAST) nxt[wr_sel] = wr_data;
      end else if (!wr_sel[3]) begin
        if (wr_sel[2]) nxt[{2'b00, wr_sel[1:0]}][W-1:HB] = wr_data[HB-1:0];
        else           nxt[{2'b00, wr_sel[1:0]}][HB-1:0] = wr_data[HB-1:0];
      end
    end
    if (loop_dec) nxt[I_CX] = regs[I_CX] - W'(1);
    if (wide_we) begin
      nxt[I_AX] = wide_lo;
      nxt[I_DX] = wide_hi;
    end
    if (ip_load)     nxt[I_IP] = ip_target;
    else if (ip_inc) nxt[I_IP] = regs[I_IP] + ip_step;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) regs[i] <= (i == 9) ? CS_RST : '0;
    end else begin
      regs <= nxt;
    end
  end
endmodule

module cpu_regbank_chk #(parameter int W = 16) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic         wr_byte,
  input logic [3:0]   wr_sel,
  input logic         loop_dec,
  input logic         loop_taken,
  input logic         wide_we,
  input logic [W-1:0] wide_hi,
  input logic [W-1:0] wide_lo,
  input logic         ip_load,
  input logic [W-1:0] ip_target,
  input logic         ip_inc,
  input logic [W-1:0] ip_step,
  input logic [W-1:0] ax,
  input logic [W-1:0] cx,
  input logic [W-1:0] dx,
  input logic [W-1:0] ip
);
  p_loop_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    loop_dec |=> cx == W'($past(cx) - W'(1)));
  p_loop_taken_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_dec && loop_taken) |=> cx != '0);
  p_loop_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_dec && !loop_taken) |=> cx == '0);
  p_wide_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wide_we |=> (ax == $past(wide_lo) && dx == $past(wide_hi)));
  p_ip_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ip_load |=> ip == $past(ip_target));
  p_ip_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ip_inc && !ip_load) |=> ip == W'($past(ip) + $past(ip_step)));
  p_ip_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ip_load && !ip_inc && !(wr_en && !wr_byte && wr_sel == 4'd12)) |=> $stable(ip));
endmodule

bind cpu_regbank cpu_regbank_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_byte(wr_byte), .wr_sel(wr_sel),
  .loop_dec(loop_dec), .loop_taken(loop_taken), .wide_we(wide_we),
  .wide_hi(wide_hi), .wide_lo(wide_lo), .ip_load(ip_load), .ip_target(ip_target),
  .ip_inc(ip_inc), .ip_step(ip_step),
  .ax(regs[0]), .cx(regs[1]), .dx(regs[2]), .ip(regs[12])
);

// File: tb/cpu_regbank_tb.sv
`timescale 1ns/1ps
module cpu_regbank_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] rd_a_sel = '0, rd_b_sel = '0, wr_sel = '0;
  logic rd_a_byte = 1'b0, rd_b_byte = 1'b0, wr_en = 1'b0, wr_byte = 1'b0;
  logic [15:0] wr_data = '0, wide_hi = '0, wide_lo = '0, ip_target = '0, ip_step = '0;
  logic loop_dec = 1'b0, wide_we = 1'b0, ip_load = 1'b0, ip_inc = 1'b0;
  logic [15:0] rd_a_data, rd_b_data;
  logic loop_taken;
  logic [19:0] fetch_addr;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cpu_regbank u_dut (
    .clk(clk), .rst_n(rst_n),
    .rd_a_sel(rd_a_sel), .rd_a_byte(rd_a_byte), .rd_a_data(rd_a_data),
    .rd_b_sel(rd_b_sel), .rd_b_byte(rd_b_byte), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_byte(wr_byte), .wr_data(wr_data),
    .loop_dec(loop_dec), .loop_taken(loop_taken),
    .wide_we(wide_we), .wide_hi(wide_hi), .wide_lo(wide_lo),
    .ip_load(ip_load), .ip_target(ip_target), .ip_inc(ip_inc), .ip_step(ip_step),
    .fetch_addr(fetch_addr)
  );

  // {wr_byte, wr_sel, wr_data, rd_byte, rd_sel, expected}
  localparam int NV = 12;
  localparam logic [41:0] VEC [NV] = '{
    {1'b0, 4'd0,  16'h1234, 1'b0, 4'd0,  16'h1234},
    {1'b1, 4'd4,  16'h00AB, 1'b0, 4'd0,  16'hAB34},
    {1'b1, 4'd0,  16'hFFCD, 1'b0, 4'd0,  16'hABCD},
    {1'b0, 4'd3,  16'hBEEF, 1'b1, 4'd7,  16'h00BE},
    {1'b0, 4'd7,  16'h5A5A, 1'b1, 4'd3,  16'h00EF},
    {1'b0, 4'd11, 16'h2000, 1'b0, 4'd11, 16'h2000},
    {1'b0, 4'd13, 16'h0F0F, 1'b0, 4'd13, 16'h0F0F},
    {1'b0, 4'd14, 16'hFFFF, 1'b0, 4'd14, 16'h0000},
    {1'b1, 4'd9,  16'h0011, 1'b0, 4'd9,  16'hFFFF},
    {1'b1, 4'd5,  16'h007E, 1'b0, 4'd1,  16'h7E00},
    {1'b0, 4'd6,  16'h0102, 1'b0, 4'd7,  16'h5A5A},
    {1'b1, 4'd2,  16'h0099, 1'b1, 4'd6,  16'h0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle;
    @(negedge clk);
    wr_en = 0; loop_dec = 0; wide_we = 0; ip_load = 0; ip_inc = 0;
  endtask

  task automatic wword(input logic [3:0] s, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_byte = 0; wr_sel = s; wr_data = d;
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    for (int s = 0; s < 16; s++) begin
      rd_a_sel = 4'(s); rd_a_byte = 0; #1;
      chk("R1 reset register", 32'(rd_a_data), (s == 9) ? 32'hFFFF : 32'h0);
    end
    chk("R1 reset fetch_addr", 32'(fetch_addr), 32'hFFFF0);

    // R2 R3 R4 table walk
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      wr_en = 1; wr_byte = VEC[v][41]; wr_sel = VEC[v][40:37]; wr_data = VEC[v][36:21];
      rd_a_byte = VEC[v][20]; rd_a_sel = VEC[v][19:16];
      idle();
      #1;
      chk($sformatf("R2/R3/R4 vector %0d", v), 32'(rd_a_data), 32'(VEC[v][15:0]));
    end

    // R10 independent read ports
    rd_a_sel = 4'd0; rd_a_byte = 0; rd_b_sel = 4'd4; rd_b_byte = 1; #1;
    chk("R10 port a", 32'(rd_a_data), 32'hABCD);
    chk("R10 port b", 32'(rd_b_data), 32'h00AB);

    // R5 loop decrement
    wword(4'd1, 16'h0002);
    rd_a_sel = 4'd1; rd_a_byte = 0;
    @(negedge clk); loop_dec = 1; #1;
    chk("R5 taken at cx=2", 32'(loop_taken), 32'h1);
    idle(); #1;
    chk("R5 cx after dec", 32'(rd_a_data), 32'h0001);
    @(negedge clk); loop_dec = 1; #1;
    chk("R5 not taken at cx=1", 32'(loop_taken), 32'h0);
    idle(); #1;
    chk("R5 cx reaches zero", 32'(rd_a_data), 32'h0000);
    @(negedge clk); loop_dec = 1; #1;
    chk("R5 taken at cx=0", 32'(loop_taken), 32'h1);
    idle(); #1;
    chk("R5 cx wraps", 32'(rd_a_data), 32'hFFFF);

    // R8 loop port beats general write
    @(negedge clk);
    loop_dec = 1; wr_en = 1; wr_byte = 0; wr_sel = 4'd1; wr_data = 16'h1111;
    idle(); #1;
    chk("R8 loop over write", 32'(rd_a_data), 32'hFFFE);

    // R6 wide pair, with R8 conflict on DX
    @(negedge clk);
    wide_we = 1; wide_hi = 16'hDEAD; wide_lo = 16'hBEEF;
    wr_en = 1; wr_byte = 0; wr_sel = 4'd2; wr_data = 16'h5555;
    idle();
    rd_a_sel = 4'd0; rd_b_sel = 4'd2; rd_b_byte = 0; #1;
    chk("R6 ax low half", 32'(rd_a_data), 32'hBEEF);
    chk("R6 R8 dx high half", 32'(rd_b_data), 32'hDEAD);

    // R7 instruction pointer, R9 fetch address
    rd_a_sel = 4'd12;
    @(negedge clk); ip_load = 1; ip_target = 16'h0100;
    idle(); #1;
    chk("R7 ip load", 32'(rd_a_data), 32'h0100);
    chk("R9 fetch wraps", 32'(fetch_addr), 32'h000F0);
    @(negedge clk); ip_inc = 1; ip_step = 16'h0003;
    idle(); #1;
    chk("R7 ip inc", 32'(rd_a_data), 32'h0103);
    @(negedge clk); ip_load = 1; ip_inc = 1; ip_target = 16'h0200;
    idle(); #1;
    chk("R7 load beats inc", 32'(rd_a_data), 32'h0200);
    @(negedge clk);
    ip_inc = 1; ip_step = 16'h0002; wr_en = 1; wr_byte = 0; wr_sel = 4'd12; wr_data = 16'h7777;
    idle(); #1;
    chk("R8 ip port over write", 32'(rd_a_data), 32'h0202);
    wword(4'd9, 16'h1234); #1;
    chk("R9 fetch sum", 32'(fetch_addr), 32'h12542);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule